// File: doc/BRIEF.md
# Low-Power Mode Clock Gating Controller

This block turns the four power-mode bits of a processor status word into run enables for the CPU clock, the peripheral (subsystem) clock, the slow auxiliary clock, the digitally controlled oscillator (DCO) with its bias generator, and the low-frequency oscillator. A source is kept running whenever a running clock is drawn from it, even if its own mode bit asks for it to stop.

The block also holds the status word and a small save stack so that interrupt wake-up can be modelled. Taking an interrupt saves the word and clears it, which makes the device fully active. Returning pops the saved word, and software may overwrite the saved copy while the handler runs to resume in a different mode.

All enables are registered. When a clock wakes, its source is started one edge before the clock itself. When a clock stops, its source is held one edge longer.

Top module: `lpm_clock_ctrl`

## Requirements
- R1: While rst_n is low at a clock edge, all six enables and all five status bits are 0.
- R2: In steady state, CPUOFF (status bit 0) holds mclk_en low, SCG1 (bit 3) holds smclk_en low and OSCOFF (bit 1) holds aclk_en low. Each is high when its bit is clear.
- R3: In steady state, dco_en is high exactly when a running mclk or smclk selects source code 2 (DCO). dcgen_en is high when SCG0 (bit 2) is clear or the DCO is in use.
- R4: In steady state, lfosc_en is high when OSCOFF is clear or a running mclk or smclk selects code 0 (crystal) or code 1 (internal low-power RC). Code 3 (high-frequency crystal) needs no enable from this block.
- R5: The steady outputs follow the mode encodings {SCG1,SCG0,OSCOFF,CPUOFF}: 0000 active; 0001 peripheral and aux clocks only; 0101 also lets the DCO stop when unused; 1001 aux clock with the bias generator kept on; 1101 aux clock only; 1111 everything stopped.
- R6: irq_take saves the full status word {GIE (bit 4), mode bits} and clears all five bits at the next edge.
- R7: irq_ret restores the top saved word at the next edge. stk_wr replaces the top saved word, so the resumed mode follows the modified value.
- R8: On wake-up, a clock's enable rises one edge after its source enable rises, never in the same edge.
- R9: When a clock stops, a source it was drawn from stays enabled for one more edge.
- R10: irq_ret with an empty stack and stk_wr with an empty stack are ignored. irq_take with a full stack still clears the status word but saves nothing. Nested takes restore in last-in, first-out order.
- R11: sr_wr loads sr_wdata into the status word at the next edge when neither irq_take nor irq_ret is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sr_wr | input | 1 | Load the status word from sr_wdata |
| sr_wdata | input | 5 | New status word {GIE, SCG1, SCG0, OSCOFF, CPUOFF} |
| irq_take | input | 1 | Interrupt entry: save the word and clear it |
| irq_ret | input | 1 | Return from interrupt: restore the top saved word |
| stk_wr | input | 1 | Overwrite the top saved word |
| stk_wdata | input | 5 | Replacement saved word |
| mclk_src | input | 2 | CPU clock source: 0 crystal, 1 RC, 2 DCO, 3 fast crystal |
| smclk_src | input | 2 | Peripheral clock source, same codes |
| sr_status | output | 5 | Current status word |
| mclk_en | output | 1 | CPU clock run enable |
| smclk_en | output | 1 | Peripheral clock run enable |
| aclk_en | output | 1 | Auxiliary clock run enable |
| dco_en | output | 1 | DCO run enable |
| dcgen_en | output | 1 | DCO bias generator enable |
| lfosc_en | output | 1 | Low-frequency oscillator enable |

## Verification
The bench builds the controller with a save stack only two entries deep. This brings the full-stack interrupt case within reach after two nested entries, and the empty-stack return after the same short sequence. The source selects are swept over all four codes, so both the hold-on-use rule for the DCO and the low-frequency oscillator and the fast-crystal case without an enable are reached. Edge-exact checks around a wake-up from the deepest mode and a drop into it pin down the one-edge stagger between each clock and its source.

// File: rtl/lpm_pkg.sv
// Shared types for the low-power clock controller.
// Status word layout: [4] GIE, [3] SCG1, [2] SCG0, [1] OSCOFF, [0] CPUOFF.
package lpm_pkg;
    localparam int SR_W   = 5;
    localparam int SRC_W  = 2;
    localparam int N_CONS = 2;   // gated consumers: 0 = CPU clock, 1 = peripheral clock

    typedef struct packed {
        logic gie;
        logic scg1;
        logic scg0;
        logic oscoff;
        logic cpuoff;
    } sr_bits_t;

    typedef enum logic [SRC_W-1:0] {
        SRC_LFXT = 2'd0,
        SRC_VLO  = 2'd1,
        SRC_DCO  = 2'd2,
        SRC_HFXT = 2'd3
    } clk_src_e;
endpackage

// File: rtl/lpm_sr_stack.sv
// Status word register with a save stack for interrupt entry and return.
// Assumes irq_take and irq_ret are single-cycle pulses; take wins if both are set.
module lpm_sr_stack
    import lpm_pkg::*;
#(
    parameter int STK_DEPTH = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sr_wr,
    input  sr_bits_t sr_wdata,
    input  logic     irq_take,
    input  logic     irq_ret,
    input  logic     stk_wr,
    input  sr_bits_t stk_wdata,
    output sr_bits_t sr_q
);
    localparam int PTR_W = $clog2(STK_DEPTH + 1);
    localparam int IDX_W = (STK_DEPTH > 1) ? $clog2(STK_DEPTH) : 1;
    localparam logic [PTR_W-1:0] DEPTH_C = PTR_W'(STK_DEPTH);

    sr_bits_t         stk [STK_DEPTH];
    logic [PTR_W-1:0] cnt_q;
    logic [IDX_W-1:0] push_idx;
    logic [IDX_W-1:0] top_idx;
    logic             is_full;
    logic             is_empty;

    // Stack slot pointers derived from the occupancy count.
    always_comb begin
        push_idx = cnt_q[IDX_W-1:0];
        top_idx  = push_idx - 1'b1;
        is_full  = (cnt_q == DEPTH_C);
        is_empty = (cnt_q == '0);
    end

    // Status word and stack update on take, return and software writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q  <= '0;
            cnt_q <= '0;
            for (int i = 0; i < STK_DEPTH; i++) stk[i] <= '0;
        end else if (irq_take) begin
            if (!is_full) begin
                stk[push_idx] <= sr_q;
                cnt_q         <= cnt_q + 1'b1;
            end
            sr_q <= '0;
        end else if (irq_ret) begin
            if (!is_empty) begin
                sr_q  <= stk[top_idx];
                cnt_q <= cnt_q - 1'b1;
            end
        end else begin
            if (sr_wr) sr_q <= sr_wdata;
            if (stk_wr && !is_empty) stk[top_idx] <= stk_wdata;
        end
    end

    // R6
    take_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |=> (sr_q == '0));

    // R10
    empty_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ret && !irq_take && is_empty) |=> $stable(sr_q));

    // R10
    depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_take && is_full) |=> is_full);
endmodule

// File: rtl/lpm_mode_decode.sv
// Decodes the mode bits and source selects into the enable each clock and
// oscillator wants in steady state. Purely combinational.
module lpm_mode_decode
    import lpm_pkg::*;
(
    input  sr_bits_t                       sr,
    input  logic [N_CONS-1:0][SRC_W-1:0]   cons_src,
    output logic [N_CONS-1:0]              cons_want,
    output logic                           aclk_want,
    output logic                           dco_want,
    output logic                           dcgen_want,
    output logic                           lf_want
);
    logic [N_CONS-1:0] use_dco;
    logic [N_CONS-1:0] use_lf;

    // Consumer clock requests straight from the gating bits.
    always_comb begin
        cons_want[0] = !sr.cpuoff;
        cons_want[1] = !sr.scg1;
    end

    // Which source each running consumer draws from.
    for (genvar i = 0; i < N_CONS; i++) begin : g_use
        assign use_dco[i] = cons_want[i] && (cons_src[i] == SRC_DCO);
        assign use_lf[i]  = cons_want[i] &&
                            ((cons_src[i] == SRC_LFXT) || (cons_src[i] == SRC_VLO));
    end

    // Source requests: a source stays on while any running clock needs it.
    always_comb begin
        aclk_want  = !sr.oscoff;
        dco_want   = |use_dco;
        dcgen_want = !sr.scg0 || dco_want;
        lf_want    = !sr.oscoff || (|use_lf);
    end
endmodule

// File: rtl/lpm_clk_seq.sv
// Registers the enables. A consumer clock is enabled only once its source
// enable is already high. A source is held while a consumer enabled on it drops.
// Assumes source selects change rarely compared with mode changes.
module lpm_clk_seq
    import lpm_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [N_CONS-1:0]            cons_want,
    input  logic [N_CONS-1:0][SRC_W-1:0] cons_src,
    input  logic                         aclk_want,
    input  logic                         dco_want,
    input  logic                         dcgen_want,
    input  logic                         lf_want,
    output logic [N_CONS-1:0]            cons_en_q,
    output logic                         aclk_en_q,
    output logic                         dco_en_q,
    output logic                         dcgen_en_q,
    output logic                         lf_en_q
);
    logic [N_CONS-1:0] src_ready;
    logic [N_CONS-1:0] hold_dco;
    logic [N_CONS-1:0] hold_lf;

    // Per-consumer source readiness and hold terms.
    for (genvar i = 0; i < N_CONS; i++) begin : g_cons
        assign src_ready[i] = (cons_src[i] == SRC_DCO)  ? dco_en_q :
                              (cons_src[i] == SRC_HFXT) ? 1'b1     : lf_en_q;
        assign hold_dco[i]  = cons_en_q[i] && (cons_src[i] == SRC_DCO);
        assign hold_lf[i]   = cons_en_q[i] &&
                              ((cons_src[i] == SRC_LFXT) || (cons_src[i] == SRC_VLO));

        // R8
        wake_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(cons_en_q[i]) && ($past(cons_src[i]) == SRC_DCO)) |-> $past(dco_en_q));

        // R9
        stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(cons_en_q[i]) && (cons_src[i] == SRC_DCO) &&
             ($past(cons_src[i]) == SRC_DCO)) |-> dco_en_q);
    end

    // Enable registers: clocks wait for their source, sources wait for their users.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cons_en_q  <= '0;
            aclk_en_q  <= 1'b0;
            dco_en_q   <= 1'b0;
            dcgen_en_q <= 1'b0;
            lf_en_q    <= 1'b0;
        end else begin
            cons_en_q  <= cons_want & src_ready;
            aclk_en_q  <= aclk_want && lf_en_q;
            dco_en_q   <= dco_want || (|hold_dco);
            dcgen_en_q <= dcgen_want || (|hold_dco);
            lf_en_q    <= lf_want || (|hold_lf) || aclk_en_q;
        end
    end

    // R8
    aclk_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(aclk_en_q) |-> $past(lf_en_q));
endmodule

// File: rtl/lpm_clock_ctrl.sv
// Top level: status word with save stack, mode decode and enable sequencing.
// Assumes a single clock domain; the enables feed glitch-free gates elsewhere.
module lpm_clock_ctrl
    import lpm_pkg::*;
#(
    parameter int STK_DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sr_wr,
    input  logic [SR_W-1:0]  sr_wdata,
    input  logic             irq_take,
    input  logic             irq_ret,
    input  logic             stk_wr,
    input  logic [SR_W-1:0]  stk_wdata,
    input  logic [SRC_W-1:0] mclk_src,
    input  logic [SRC_W-1:0] smclk_src,
    output logic [SR_W-1:0]  sr_status,
    output logic             mclk_en,
    output logic             smclk_en,
    output logic             aclk_en,
    output logic             dco_en,
    output logic             dcgen_en,
    output logic             lfosc_en
);
    sr_bits_t                     sr_q;
    logic [N_CONS-1:0][SRC_W-1:0] cons_src;
    logic [N_CONS-1:0]            cons_want;
    logic [N_CONS-1:0]            cons_en;
    logic                         aclk_want;
    logic                         dco_want;
    logic                         dcgen_want;
    logic                         lf_want;

    // Gather consumer source selects in consumer index order.
    always_comb begin
        cons_src[0] = mclk_src;
        cons_src[1] = smclk_src;
    end

    lpm_sr_stack #(.STK_DEPTH(STK_DEPTH)) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .sr_wr     (sr_wr),
        .sr_wdata  (sr_bits_t'(sr_wdata)),
        .irq_take  (irq_take),
        .irq_ret   (irq_ret),
        .stk_wr    (stk_wr),
        .stk_wdata (sr_bits_t'(stk_wdata)),
        .sr_q      (sr_q)
    );

    lpm_mode_decode u_dec (
        .sr         (sr_q),
        .cons_src   (cons_src),
        .cons_want  (cons_want),
        .aclk_want  (aclk_want),
        .dco_want   (dco_want),
        .dcgen_want (dcgen_want),
        .lf_want    (lf_want)
    );

    lpm_clk_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cons_want  (cons_want),
        .cons_src   (cons_src),
        .aclk_want  (aclk_want),
        .dco_want   (dco_want),
        .dcgen_want (dcgen_want),
        .lf_want    (lf_want),
        .cons_en_q  (cons_en),
        .aclk_en_q  (aclk_en),
        .dco_en_q   (dco_en),
        .dcgen_en_q (dcgen_en),
        .lf_en_q    (lfosc_en)
    );

    // Drive the output ports.
    always_comb begin
        sr_status = sr_q;
        mclk_en   = cons_en[0];
        smclk_en  = cons_en[1];
    end

    // R2
    mclk_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sr_q.cpuoff) |-> !mclk_en);

    // R2
    smclk_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sr_q.scg1) |-> !smclk_en);

    // R2
    aclk_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sr_q.oscoff) |-> !aclk_en);

    // R3
    gen_under_dco_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dco_en |-> dcgen_en);
endmodule

// File: tb/lpm_clock_ctrl_test.sv
module lpm_clock_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sr_wr = 1'b0;
    logic [4:0] sr_wdata = '0;
    logic       irq_take = 1'b0;
    logic       irq_ret = 1'b0;
    logic       stk_wr = 1'b0;
    logic [4:0] stk_wdata = '0;
    logic [1:0] mclk_src = 2'd2;
    logic [1:0] smclk_src = 2'd2;
    logic [4:0] sr_status;
    logic       mclk_en, smclk_en, aclk_en, dco_en, dcgen_en, lfosc_en;
    logic [5:0] outs;

    int nchk = 0;
    int nerr = 0;

    always #4 clk = ~clk;   // 125 MHz

    lpm_clock_ctrl #(.STK_DEPTH(2)) uut (
        .clk(clk), .rst_n(rst_n), .sr_wr(sr_wr), .sr_wdata(sr_wdata),
        .irq_take(irq_take), .irq_ret(irq_ret), .stk_wr(stk_wr), .stk_wdata(stk_wdata),
        .mclk_src(mclk_src), .smclk_src(smclk_src), .sr_status(sr_status),
        .mclk_en(mclk_en), .smclk_en(smclk_en), .aclk_en(aclk_en),
        .dco_en(dco_en), .dcgen_en(dcgen_en), .lfosc_en(lfosc_en)
    );

    assign outs = {mclk_en, smclk_en, aclk_en, dco_en, dcgen_en, lfosc_en};

    // {req, mode{SCG1,SCG0,OSCOFF,CPUOFF}, mclk_src, smclk_src, expected outs}
    localparam logic [17:0] VEC [13] = '{
        {4'd5, 4'b0000, 2'd2, 2'd2, 6'b111111},  // R5 active
        {4'd5, 4'b0001, 2'd2, 2'd2, 6'b011111},  // R5 CPU clock off
        {4'd5, 4'b0101, 2'd2, 2'd2, 6'b011111},  // R5 DCO still used by peripheral clock
        {4'd3, 4'b0101, 2'd2, 2'd0, 6'b011001},  // R3 DCO unused, stops with generator
        {4'd5, 4'b1001, 2'd2, 2'd2, 6'b001011},  // R5 generator kept on
        {4'd5, 4'b1101, 2'd2, 2'd2, 6'b001001},  // R5 aux clock only
        {4'd5, 4'b1111, 2'd2, 2'd2, 6'b000000},  // R5 all stopped
        {4'd4, 4'b0010, 2'd0, 2'd2, 6'b110111},  // R4 LF kept by CPU clock
        {4'd3, 4'b0110, 2'd2, 2'd3, 6'b110110},  // R3 DCO kept by CPU clock
        {4'd3, 4'b0100, 2'd3, 2'd3, 6'b111001},  // R3 fast crystal on both
        {4'd4, 4'b0000, 2'd3, 2'd0, 6'b111011},  // R4 no DCO user
        {4'd2, 4'b0011, 2'd2, 2'd1, 6'b010011},  // R2 CPU and aux gated
        {4'd2, 4'b1111, 2'd0, 2'd0, 6'b000000}   // R2 LF users stopped
    };

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic write_sr(input logic [4:0] v);
        sr_wr = 1'b1; sr_wdata = v;
        step(1);
        sr_wr = 1'b0;
    endtask

    task automatic take();
        irq_take = 1'b1;
        step(1);
        irq_take = 1'b0;
    endtask

    task automatic ret();
        irq_ret = 1'b1;
        step(1);
        irq_ret = 1'b0;
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
        report();
    end

    initial begin
        step(3);
        chk("R1 enables in reset", 32'(outs), 32'h0);
        chk("R1 status in reset", 32'(sr_status), 32'h0);
        rst_n = 1'b1;

        // Table of steady-state modes (R2 R3 R4 R5, status load R11).
        for (int k = 0; k < 13; k++) begin
            mclk_src  = VEC[k][9:8];
            smclk_src = VEC[k][7:6];
            write_sr({1'b0, VEC[k][13:10]});
            chk("R11 status load", 32'(sr_status), 32'(VEC[k][13:10]));
            step(5);
            chk($sformatf("R%0d row %0d", VEC[k][17:14], k), 32'(outs), 32'(VEC[k][5:0]));
        end

        // R8: wake from the deepest mode with both clocks on the DCO.
        mclk_src = 2'd2; smclk_src = 2'd2;
        write_sr(5'b01111);
        step(5);
        take();
        chk("R6 status cleared on take", 32'(sr_status), 32'h0);
        chk("R8 no clock in the mode edge", 32'(outs), 32'h0);
        step(1);
        chk("R8 source first", 32'({dco_en, lfosc_en, mclk_en, smclk_en}), 32'b1100);
        step(1);
        chk("R8 clocks one edge later", 32'(outs), 32'b111111);

        // R7: plain return restores the saved mode.
        ret();
        chk("R7 restore", 32'(sr_status), 32'b01111);
        step(5);
        chk("R7 restored mode outputs", 32'(outs), 32'h0);

        // R7: handler rewrites the saved copy to resume in a lighter mode.
        write_sr(5'b11101);
        take();
        stk_wr = 1'b1; stk_wdata = 5'b00001;
        step(1);
        stk_wr = 1'b0;
        ret();
        chk("R7 modified restore", 32'(sr_status), 32'b00001);
        step(5);
        chk("R7 modified mode outputs", 32'(outs), 32'b011111);

        // R10: nesting, full stack and empty stack.
        write_sr(5'b11001);
        take();
        write_sr(5'b10000);
        take();
        write_sr(5'b10100);
        take();
        chk("R10 full take still clears", 32'(sr_status), 32'h0);
        ret();
        chk("R10 inner restore", 32'(sr_status), 32'b10000);
        ret();
        chk("R10 outer restore", 32'(sr_status), 32'b11001);
        ret();
        chk("R10 empty return ignored", 32'(sr_status), 32'b11001);
        stk_wr = 1'b1; stk_wdata = 5'b00000;
        step(1);
        stk_wr = 1'b0;
        ret();
        chk("R10 empty stack write ignored", 32'(sr_status), 32'b11001);

        // R9: dropping from active to all-off holds the DCO one edge.
        write_sr(5'b00000);
        step(5);
        write_sr(5'b01111);
        step(1);
        chk("R9 clocks off, source held", 32'({mclk_en, smclk_en, dco_en, dcgen_en}), 32'b0011);
        step(1);
        chk("R9 source off next edge", 32'({dco_en, dcgen_en}), 32'b00);

        // R1: reset again from an active state.
        write_sr(5'b10000);
        step(5);
        rst_n = 1'b0;
        step(1);
        chk("R1 enables after reset edge", 32'(outs), 32'h0);
        chk("R1 status after reset edge", 32'(sr_status), 32'h0);

        report();
    end
endmodule